// File: doc/BRIEF.md
# Edge Phase Detector with Qualified Lock Flag

This block is the digital phase detector of a spindle speed loop. It compares a reference clock with a tach pulse taken from one Hall sensor phase. Both asynchronous inputs are synchronized to the system clock. The reference is compared on its falling edges and the tach pulse on its rising edges. When the reference edge arrives first, `up` is high for as many system clocks as the tach edge lags. When the tach edge arrives first, `dn` is high for as many clocks as the reference lags. When both edges have arrived, both requests return low. A downstream charge pump or digital filter turns these pulses into motor drive.

Each completed comparison is checked against a programmable window. Lock is declared only after a run of `LOCK_CNT` consecutive slow timebase periods. In each of these periods at least one comparison must complete and every comparison must land inside the window. Any out-of-window comparison, and any slow period with no comparison at all, clears the run at once. A mask input suppresses the active-low lock output without changing the lock flag. A stop command holds the detector idle and clears lock.

Top module: `phase_lock_detector`

## Requirements
- R1: While reset is held, `up`, `dn` and `locked` are 0 and `lock_n` is 1.
- R2: The reference input is compared only on its falling edge. A rising reference edge produces no pulse.
- R3: The tach input is compared only on its rising edge. A falling tach edge produces no pulse.
- R4: If the tach rising edge follows the reference falling edge by d clocks (d > 0), `up` is high for exactly d clocks and `dn` stays low.
- R5: If the reference falling edge follows the tach rising edge by d clocks (d > 0), `dn` is high for exactly d clocks and `up` stays low.
- R6: Edges arriving in the same clock produce no pulse on either output and count as a comparison with zero error.
- R7: A comparison is in-window when its error in clocks is strictly below `win_lim`. `locked` rises after `LOCK_CNT` (default 7) consecutive `tick` strobes. Each of those strobes must have seen, since the previous strobe, at least one completed comparison and no out-of-window one. A comparison completing in the same cycle as the strobe belongs to that strobe's period.
- R8: An out-of-window comparison clears `locked` in the next cycle. It takes precedence over a `tick` in the same cycle.
- R9: A `tick` that arrives with no completed comparison since the previous `tick` clears `locked`.
- R10: `lock_n` is 0 exactly when `locked` is 1 and `lock_mask` is 0. `lock_mask` has no effect on `locked`.
- R11: While `stop` is 1, `up` and `dn` stay low and `locked` is cleared.
- R12: Each input passes through a two-stage synchronizer. `up` first shows high on the third rising clock edge after the reference input falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| stop | input | 1 | Stop command; idles detector and clears lock |
| ref_clk_in | input | 1 | Asynchronous reference clock |
| fb_tach_in | input | 1 | Asynchronous tach pulse from a Hall phase |
| tick | input | 1 | One-cycle strobe from the slow timebase |
| win_lim | input | ERR_W | Lock window in system clocks |
| lock_mask | input | 1 | Forces the lock output inactive |
| up | output | 1 | Speed-up request, width equals phase error |
| dn | output | 1 | Slow-down request, width equals phase error |
| locked | output | 1 | Qualified lock flag |
| lock_n | output | 1 | Active-low, maskable lock output |

## Verification
The lock qualifier can see a completed comparison and a timebase strobe in the same clock. The bench provokes this by forcing `tick` on the exact cycle after the tach strobe, a cycle it computes from the synchronizer depth and the edge spacing. It does this once with an error equal to `win_lim`, which must drop an established lock, showing that the clear wins. It also does this seven times in a row with in-window errors, which must build a lock from zero, showing that a same-cycle completion counts for the strobe it meets.

// File: rtl/pld_pkg.sv
package pld_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_UP   = 2'd1,
      PH_DN   = 2'd2
   } ph_state_e;
endpackage

// File: rtl/pld_edge_sync.sv
module pld_edge_sync #(
   parameter int STAGES = 2,
   parameter bit RISE   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic stb
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pld_edge_sync: STAGES must be at least 2");
   end

   logic [STAGES:0] shreg;
   logic            cur, prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) shreg <= '0;
      else        shreg <= {shreg[STAGES-1:0], din};
   end

   assign cur  = shreg[STAGES-1];
   assign prev = shreg[STAGES];

   if (RISE) begin : g_rise
      assign stb = cur & ~prev;
   end else begin : g_fall
      assign stb = ~cur & prev;
   end
endmodule

// File: rtl/pld_phase_cmp.sv
module pld_phase_cmp
   import pld_pkg::*;
#(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          stop,
   input  logic          ref_stb,
   input  logic          fb_stb,
   output logic          up,
   output logic          dn,
   output logic          done,
   output logic [CW-1:0] err
);
   if (CW < 2) begin : g_bad_cw
      $error("pld_phase_cmp: CW must be at least 2");
   end

   localparam logic [CW-1:0] CNT_MAX = '1;

   ph_state_e     st;
   logic [CW-1:0] cnt;
   logic [CW-1:0] cnt_inc;

   assign cnt_inc = (cnt == CNT_MAX) ? cnt : cnt + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= PH_IDLE;
         cnt  <= '0;
         done <= 1'b0;
         err  <= '0;
      end else if (stop) begin
         st   <= PH_IDLE;
         cnt  <= '0;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         case (st)
            PH_IDLE: begin
               cnt <= '0;
               if (ref_stb && fb_stb) begin
                  done <= 1'b1;
                  err  <= '0;
               end else if (ref_stb) begin
                  st <= PH_UP;
               end else if (fb_stb) begin
                  st <= PH_DN;
               end
            end
            PH_UP: begin
               if (fb_stb) begin
                  st   <= PH_IDLE;
                  done <= 1'b1;
                  err  <= cnt_inc;
               end else begin
                  cnt <= cnt_inc;
               end
            end
            PH_DN: begin
               if (ref_stb) begin
                  st   <= PH_IDLE;
                  done <= 1'b1;
                  err  <= cnt_inc;
               end else begin
                  cnt <= cnt_inc;
               end
            end
            default: st <= PH_IDLE;
         endcase
      end
   end

   assign up = (st == PH_UP);
   assign dn = (st == PH_DN);

   // R4
   up_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(up) |-> $past(ref_stb) && !$past(fb_stb));
   // R4
   up_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(up) |-> $past(fb_stb) || $past(stop));
   // R5
   dn_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dn) |-> $past(fb_stb) && !$past(ref_stb));
   // R11
   stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop |=> !up && !dn);
endmodule

// File: rtl/pld_lock_qual.sv
module pld_lock_qual #(
   parameter int CW       = 8,
   parameter int LOCK_CNT = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          stop,
   input  logic          tick,
   input  logic          done,
   input  logic [CW-1:0] err,
   input  logic [CW-1:0] win_lim,
   output logic          locked
);
   if (LOCK_CNT < 1) begin : g_bad_cnt
      $error("pld_lock_qual: LOCK_CNT must be at least 1");
   end

   localparam int            RW      = $clog2(LOCK_CNT + 1);
   localparam logic [RW-1:0] RUN_MAX = RW'(LOCK_CNT);

   logic [RW-1:0] run;
   logic          seen;
   logic          good, bad;

   assign good = done && (err < win_lim);
   assign bad  = done && !(err < win_lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run  <= '0;
         seen <= 1'b0;
      end else if (stop || bad) begin
         run  <= '0;
         seen <= 1'b0;
      end else if (tick) begin
         seen <= 1'b0;
         if (seen || good) run <= (run == RUN_MAX) ? run : run + 1'b1;
         else              run <= '0;
      end else if (good) begin
         seen <= 1'b1;
      end
   end

   assign locked = (run == RUN_MAX);

   // R8
   bad_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done && (err >= win_lim) |=> !locked);
   // R7
   lock_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> $past(tick));
   // R11
   stop_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop |=> !locked);
endmodule

// File: rtl/phase_lock_detector.sv
module phase_lock_detector #(
   parameter int SYNC_STAGES = 2,
   parameter int ERR_W       = 8,
   parameter int LOCK_CNT    = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             stop,
   input  logic             ref_clk_in,
   input  logic             fb_tach_in,
   input  logic             tick,
   input  logic [ERR_W-1:0] win_lim,
   input  logic             lock_mask,
   output logic             up,
   output logic             dn,
   output logic             locked,
   output logic             lock_n
);
   logic             ref_stb, fb_stb;
   logic             cmp_done;
   logic [ERR_W-1:0] cmp_err;

   pld_edge_sync #(.STAGES(SYNC_STAGES), .RISE(1'b0)) i_ref_sync (
      .clk(clk), .rst_n(rst_n), .din(ref_clk_in), .stb(ref_stb)
   );

   pld_edge_sync #(.STAGES(SYNC_STAGES), .RISE(1'b1)) i_fb_sync (
      .clk(clk), .rst_n(rst_n), .din(fb_tach_in), .stb(fb_stb)
   );

   pld_phase_cmp #(.CW(ERR_W)) i_cmp (
      .clk(clk), .rst_n(rst_n), .stop(stop),
      .ref_stb(ref_stb), .fb_stb(fb_stb),
      .up(up), .dn(dn), .done(cmp_done), .err(cmp_err)
   );

   pld_lock_qual #(.CW(ERR_W), .LOCK_CNT(LOCK_CNT)) i_qual (
      .clk(clk), .rst_n(rst_n), .stop(stop), .tick(tick),
      .done(cmp_done), .err(cmp_err), .win_lim(win_lim),
      .locked(locked)
   );

   assign lock_n = ~(locked & ~lock_mask);

   // R10
   mask_keeps_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock_mask) |-> $stable(locked) || $past(stop) || $past(tick) || $past(cmp_done));
endmodule

// File: tb/test_phase_lock_detector.sv
`timescale 1ns/1ps
module test_phase_lock_detector;
   localparam int P  = 40;
   localparam int TP = 80;
   localparam int VEC_N = 8;
   // offset of tach rise vs reference fall, expected up width, expected dn width
   localparam int VEC [VEC_N][3] = '{
      '{ 5,  5, 0}, '{-3, 0, 3}, '{ 0, 0, 0}, '{ 1, 1, 0},
      '{-1,  0, 1}, '{12, 12, 0}, '{-7, 0, 7}, '{ 3, 3, 0}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       stop = 1'b0;
   logic       ref_clk_in = 1'b1;
   logic       fb_tach_in = 1'b0;
   logic       tick = 1'b0;
   logic [7:0] win_lim = 8'd4;
   logic       lock_mask = 1'b0;
   logic       up, dn, locked, lock_n;

   int  total = 0;
   int  bad = 0;
   bit  auto_en = 1'b0;
   int  tcnt = 0;

   always #2.5 clk = ~clk;

   phase_lock_detector i_phase_lock_detector (
      .clk(clk), .rst_n(rst_n), .stop(stop),
      .ref_clk_in(ref_clk_in), .fb_tach_in(fb_tach_in), .tick(tick),
      .win_lim(win_lim), .lock_mask(lock_mask),
      .up(up), .dn(dn), .locked(locked), .lock_n(lock_n)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // One reference period; off>=0: ref falls at i=2, tach rises at 2+off.
   task automatic run_period(input int off, input int tick_at, input bit edges,
                             output int n_up, output int n_dn, output int first_up);
      int rf, ff;
      rf = (off >= 0) ? 2 : 2 - off;
      ff = (off >= 0) ? 2 + off : 2;
      n_up = 0; n_dn = 0; first_up = -1;
      for (int i = 0; i < P; i++) begin
         @(negedge clk);
         if (up) begin
            n_up++;
            if (first_up < 0) first_up = i;
         end
         if (dn) n_dn++;
         tick = (auto_en && tcnt == TP - 1) || (i == tick_at);
         if (auto_en) tcnt = (tcnt == TP - 1) ? 0 : tcnt + 1;
         if (edges && i == rf) ref_clk_in = 1'b0;
         if (edges && i == ff) fb_tach_in = 1'b1;
         if (i == P / 2) begin
            ref_clk_in = 1'b1;
            fb_tach_in = 1'b0;
         end
      end
      @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic periods(input int n, input int off, input int tick_at);
      int a, b, c;
      for (int k = 0; k < n; k++) run_period(off, tick_at, 1'b1, a, b, c);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int nu, nd, fu;
      repeat (4) @(negedge clk);
      // R1 reset state
      check(up == 1'b0 && dn == 1'b0, "R1 pulses", {up, dn}, 0);
      check(locked == 1'b0, "R1 locked", locked, 0);
      check(lock_n == 1'b1, "R1 lock_n", lock_n, 1);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // vector table: R2 R3 R4 R5 R6 R12
      for (int v = 0; v < VEC_N; v++) begin
         run_period(VEC[v][0], -1, 1'b1, nu, nd, fu);
         check(nu == VEC[v][1], "R4,R2 up width", nu, VEC[v][1]);
         check(nd == VEC[v][2], "R5,R3 dn width", nd, VEC[v][2]);
         if (VEC[v][0] == 0) check(nu + nd == 0, "R6 coincident", nu + nd, 0);
         if (VEC[v][0] > 0) check(fu == 5, "R12 latency", fu, 5);
      end

      // lock on free-running ticks, R7
      auto_en = 1'b1;
      tcnt = 0;
      periods(4, 2, -1);
      check(locked == 1'b0, "R7 early", locked, 0);
      periods(14, 2, -1);
      check(locked == 1'b1, "R7 locked", locked, 1);
      check(lock_n == 1'b0, "R10 lock_n active", lock_n, 0);
      // R10 mask
      lock_mask = 1'b1;
      @(negedge clk);
      check(lock_n == 1'b1, "R10 masked", lock_n, 1);
      check(locked == 1'b1, "R10 flag kept", locked, 1);
      lock_mask = 1'b0;
      // R8 out of window
      periods(1, 8, -1);
      check(locked == 1'b0, "R8 drop", locked, 0);
      auto_en = 1'b0;

      // R7 same-cycle completion and tick
      periods(6, 2, 7);
      check(locked == 1'b0, "R7 six ticks", locked, 0);
      periods(1, 2, 7);
      check(locked == 1'b1, "R7 seventh tick", locked, 1);

      // R11 stop
      stop = 1'b1;
      run_period(5, -1, 1'b1, nu, nd, fu);
      check(nu + nd == 0, "R11 no pulses", nu + nd, 0);
      check(locked == 1'b0, "R11 unlocked", locked, 0);
      stop = 1'b0;

      // R8 priority: error equal to window, tick same cycle
      periods(7, 3, 8);
      check(locked == 1'b1, "R7 relock", locked, 1);
      periods(1, 4, 9);
      check(locked == 1'b0, "R8 priority", locked, 0);

      // R9 tick without any comparison
      periods(7, 3, 8);
      check(locked == 1'b1, "R9 relock", locked, 1);
      run_period(0, 10, 1'b0, nu, nd, fu);
      check(locked == 1'b0, "R9 idle tick", locked, 0);
      check(lock_n == 1'b1, "R10 inactive", lock_n, 1);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule